// File: doc/BRIEF.md
# Serial Transmitter with Synchronous Idle Fill

This block is the parallel-to-serial half of a programmable serial port. A host writes one character at a time into a holding register. The block then moves it into a shift register and sends it on the serial line. In asynchronous mode each character is framed with a start bit, an optional parity bit and a programmable stop period. Each bit lasts 1, 16 or 64 periods of the transmit clock. In synchronous mode the character is sent with no framing, one bit per transmit clock. When no data is pending, the block keeps the line busy with one or two stored sync characters.

The transmit clock `txClk` is a slow input that is sampled by the system clock `clk`. Every falling edge seen on it is one transmit tick, and the line changes only on ticks. Configuration comes from a separate control sequencer and must stay stable while characters are being sent. Two command levels, enable and break, and the active-low clear-to-send input control when the line may carry data.

Top module: `usart_tx`

## Requirements
- R1: After a reset cycle (`rst` high at a `clk` edge), `txd` is 1, `txRdy` is 1 and `txEmpty` is 1.
- R2: At any tick with `cmdTxEn` low, `txd` goes to 1 (unless break is set), and the character in progress is dropped. A character still in the holding register is kept.
- R3: A new character starts only at a tick where `cmdTxEn` is 1 and `ctsN` is 0. A character that has already started runs to completion even if `ctsN` rises.
- R4: An asynchronous character is sent as: a start bit of 0, then 5+`cfgLen` data bits LSB first, then a parity bit if `cfgParEn` is 1, then the stop period at 1. The parity bit is the XOR of the data bits, inverted when `cfgParOdd` is 1.
- R5: In asynchronous mode every bit lasts F ticks. F is 1 for `cfgBaud`=00, 16 for 01, and 64 for 1x.
- R6: The stop period is F ticks for `cfgStop`=00, 1.5·F ticks for 01 (rounded up to whole ticks, so 2 ticks when F=1), and 2·F ticks for 1x. A waiting character starts on the tick right after the stop period ends.
- R7: A tick is a `clk` edge where `txClk` was 1 at the previous edge and is 0 now. `txd` changes only on the `clk` edge of a tick.
- R8: `txRdy` is 0 from the `clk` edge after `wrData` until the tick on which the holding register moves into the shift register. A write while `txRdy` is 0 replaces the held character.
- R9: `txEmpty` is 1 exactly when the holding register is empty and no data character (including its stop period) is being sent.
- R10: In synchronous mode (`cfgSync`=1) a character is 5+`cfgLen` data bits LSB first plus the optional parity bit, one bit per tick, with no start or stop bits. Characters follow each other with no gap.
- R11: In synchronous mode, at a character boundary with the gate open and the holding register empty, a sync character is sent. It is `syncCharA`, or, when `cfgDualSync`=1, alternately `syncCharA` then `syncCharB`. The alternation restarts with `syncCharA` after a data character or idle time. `txEmpty` stays 1 during this fill.
- R12: At every tick while `cmdBreak` is 1, `txd` goes to 0. Character timing keeps running underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txClk | input | 1 | Transmit clock, sampled by clk; a falling edge is a tick |
| ctsN | input | 1 | Clear to send, active low |
| cmdTxEn | input | 1 | Transmit enable command |
| cmdBreak | input | 1 | Break command, forces the line low |
| cfgSync | input | 1 | 1 selects synchronous mode |
| cfgBaud | input | 2 | Asynchronous bit length: 00 x1, 01 x16, 1x x64 |
| cfgLen | input | 2 | Data bits minus 5 |
| cfgParEn | input | 1 | Parity bit enable |
| cfgParOdd | input | 1 | Odd parity select |
| cfgStop | input | 2 | Stop period: 00 one, 01 one and a half, 1x two bits |
| cfgDualSync | input | 1 | Alternate two sync characters |
| syncCharA | input | 8 | First sync character |
| syncCharB | input | 8 | Second sync character |
| wrData | input | 1 | Host write strobe for dataIn |
| dataIn | input | 8 | Character from the host |
| txd | output | 1 | Serial output |
| txRdy | output | 1 | Holding register empty |
| txEmpty | output | 1 | No data pending or being sent |

## Verification
The in-line assertions check, on every cycle, the properties of the line that are local in time. The line holds between ticks. A break or a disable takes effect on the tick where it is seen. A write always drops the ready flag. The bit-length counter stays in range, and synchronous mode never enters a stop period. The bench scenarios are needed for everything that spans a whole character: the framing order, the parity value, the exact number of ticks in each bit and each stop period, the back-to-back starts in double buffering, the CTS hold-off, and the order of the sync characters around data. A behavioural queue model builds each expected character tick by tick and checks these on every clock.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

  // Per-tick commands from the sequencer to the datapath.
  typedef struct packed {
    logic loadData;  // move holding register into the shifter
    logic loadSync;  // load the next sync character into the shifter
    logic shift;     // advance to the next frame bit
    logic mark;      // line idles high (idle or stop period)
  } txStrobe_t;

endpackage

// File: rtl/usart_tx_ctrl.sv
module usart_tx_ctrl
  import usart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       txEn,
  input  logic       ctsN,
  input  logic       syncMode,
  input  logic [1:0] baudSel,
  input  logic [1:0] lenSel,
  input  logic       parEn,
  input  logic [1:0] stopSel,
  input  logic       holdFull,
  output txStrobe_t  strb,
  output logic       busyData
);

  localparam int CNT_W  = $clog2(SLOW_DIV) + 1;
  localparam int STOP_W = CNT_W + 2;
  localparam int BIT_W  = $clog2(DATA_W + 3);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_STOP} txState_t;

  txState_t           state, stateN;
  logic [CNT_W-1:0]   subCnt, subN, factor;
  logic [BIT_W-1:0]   bitsLeft, bitsN, nBits;
  logic [STOP_W-1:0]  stopRem, stopN, halves, stopTicks;
  logic               busyN, subLast, frameDone, gate;

  always_comb begin
    if (syncMode)              factor = CNT_W'(1);
    else if (baudSel == 2'b00) factor = CNT_W'(1);
    else if (baudSel == 2'b01) factor = CNT_W'(FAST_DIV);
    else                       factor = CNT_W'(SLOW_DIV);
    case (stopSel)
      2'b00:   halves = STOP_W'(2);
      2'b01:   halves = STOP_W'(3);
      default: halves = STOP_W'(4);
    endcase
    stopTicks = (halves * STOP_W'(factor) + STOP_W'(1)) >> 1;
    nBits     = BIT_W'(5) + BIT_W'(lenSel) + BIT_W'(parEn) + BIT_W'(!syncMode);
    gate      = txEn && !ctsN;
  end

  always_comb begin
    strb      = '0;
    stateN    = state;
    subN      = subCnt;
    bitsN     = bitsLeft;
    stopN     = stopRem;
    busyN     = busyData;
    subLast   = (subCnt == factor - CNT_W'(1));
    frameDone = (state == S_IDLE)
             || (state == S_STOP && stopRem == STOP_W'(1))
             || (state == S_DATA && subLast && bitsLeft == BIT_W'(1) && syncMode);
    if (tick) begin
      if (!txEn) begin
        stateN    = S_IDLE;
        strb.mark = 1'b1;
        busyN     = 1'b0;
        subN      = '0;
      end else if (frameDone) begin
        if (gate && (holdFull || syncMode)) begin
          strb.loadData = holdFull;
          strb.loadSync = !holdFull;
          stateN        = S_DATA;
          subN          = '0;
          bitsN         = nBits;
          busyN         = holdFull;
        end else begin
          stateN    = S_IDLE;
          strb.mark = 1'b1;
          busyN     = 1'b0;
          subN      = '0;
        end
      end else if (state == S_DATA) begin
        if (subLast) begin
          subN = '0;
          if (bitsLeft == BIT_W'(1)) begin
            stateN    = S_STOP;
            stopN     = stopTicks;
            strb.mark = 1'b1;
          end else begin
            strb.shift = 1'b1;
            bitsN      = bitsLeft - BIT_W'(1);
          end
        end else begin
          subN = subCnt + CNT_W'(1);
        end
      end else begin
        stopN     = stopRem - STOP_W'(1);
        strb.mark = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      subCnt   <= '0;
      bitsLeft <= '0;
      stopRem  <= '0;
      busyData <= 1'b0;
    end else begin
      state    <= stateN;
      subCnt   <= subN;
      bitsLeft <= bitsN;
      stopRem  <= stopN;
      busyData <= busyN;
    end
  end

  // R5: the within-bit tick counter never reaches the bit length
  p_sub_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA) |-> (subCnt < factor));

  // R10: synchronous characters carry no stop period
  p_no_stop_sync_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP) |-> !syncMode);

endmodule

// File: rtl/usart_tx_dp.sv
module usart_tx_dp
  import usart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              brk,
  input  txStrobe_t         strb,
  input  logic              syncMode,
  input  logic [1:0]        lenSel,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              dualSync,
  input  logic [DATA_W-1:0] syncA,
  input  logic [DATA_W-1:0] syncB,
  input  logic              wrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic              holdFull,
  output logic              line
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int FI_W    = $clog2(FRAME_W);
  localparam int DI_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0]  holdReg, charSrc;
  logic [FRAME_W-1:0] shReg, shNext, frameVal;
  logic               syncSel, parBit;
  int                 lenInt, off;

  // Assemble the frame for the character being loaded, LSB first at bit 0.
  always_comb begin
    charSrc  = strb.loadSync ? ((syncSel && dualSync) ? syncB : syncA) : holdReg;
    lenInt   = 5 + int'(lenSel);
    off      = syncMode ? 0 : 1;
    frameVal = '1;
    parBit   = parOdd;
    if (!syncMode) frameVal[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < lenInt) begin
        parBit = parBit ^ charSrc[DI_W'(i)];
        frameVal[FI_W'(i + off)] = charSrc[DI_W'(i)];
      end
    end
    if (parEn) frameVal[FI_W'(lenInt + off)] = parBit;
  end

  always_comb begin
    if (strb.loadData || strb.loadSync) shNext = frameVal;
    else if (strb.shift)                shNext = {1'b1, shReg[FRAME_W-1:1]};
    else                                shNext = shReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shReg    <= '1;
      syncSel  <= 1'b0;
      line     <= 1'b1;
    end else begin
      if (wrData) begin
        holdReg  <= dataIn;
        holdFull <= 1'b1;
      end else if (strb.loadData) begin
        holdFull <= 1'b0;
      end
      shReg <= shNext;
      if (strb.loadSync)                    syncSel <= dualSync && !syncSel;
      else if (strb.loadData || strb.mark)  syncSel <= 1'b0;
      if (tick) line <= brk ? 1'b0 : (strb.mark ? 1'b1 : shNext[0]);
    end
  end

  // R8: a data load only ever empties a holding register that was full
  p_load_from_full_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.loadData && !wrData) |=> !holdFull);

endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txClk,
  input  logic              ctsN,
  input  logic              cmdTxEn,
  input  logic              cmdBreak,
  input  logic              cfgSync,
  input  logic [1:0]        cfgBaud,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic [1:0]        cfgStop,
  input  logic              cfgDualSync,
  input  logic [DATA_W-1:0] syncCharA,
  input  logic [DATA_W-1:0] syncCharB,
  input  logic              wrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  txStrobe_t strb;
  logic      txClkQ, tick, holdFull, busyData;

  always_ff @(posedge clk) txClkQ <= txClk;
  assign tick = txClkQ && !txClk;

  usart_tx_ctrl #(.DATA_W(DATA_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .txEn(cmdTxEn), .ctsN(ctsN),
    .syncMode(cfgSync), .baudSel(cfgBaud), .lenSel(cfgLen), .parEn(cfgParEn),
    .stopSel(cfgStop), .holdFull(holdFull), .strb(strb), .busyData(busyData)
  );

  usart_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .tick(tick), .brk(cmdBreak), .strb(strb),
    .syncMode(cfgSync), .lenSel(cfgLen), .parEn(cfgParEn), .parOdd(cfgParOdd),
    .dualSync(cfgDualSync), .syncA(syncCharA), .syncB(syncCharB),
    .wrData(wrData), .dataIn(dataIn), .holdFull(holdFull), .line(txd)
  );

  assign txRdy   = !holdFull;
  assign txEmpty = !holdFull && !busyData;

  // R2: a disabled transmitter idles at mark from the tick it is seen
  p_mark_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cmdTxEn && !cmdBreak) |=> txd);

  // R12: break pulls the line low on every tick it is held
  p_break_low_r12: assert property (@(posedge clk) disable iff (rst)
    (tick && cmdBreak) |=> !txd);

  // R7: the line only moves on a transmit clock falling edge
  p_edge_only_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  // R8: a host write always leaves the block not ready
  p_write_busy_r8: assert property (@(posedge clk) disable iff (rst)
    wrData |=> !txRdy);

endmodule

// File: tb/usart_tx_bench.sv
`timescale 1ns/100ps
module usart_tx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txClk = 1'b0;
  logic       ctsN = 1'b0, cmdTxEn = 1'b0, cmdBreak = 1'b0;
  logic       cfgSync = 1'b0, cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgDualSync = 1'b0;
  logic [1:0] cfgBaud = 2'b00, cfgLen = 2'b11, cfgStop = 2'b00;
  logic [7:0] syncCharA = 8'h16, syncCharB = 8'h7E;
  logic       wrData = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       txd, txRdy, txEmpty;

  int    checks = 0, errors = 0, cyc = 0, divCnt = 0;
  bit    finished = 0;
  string curReq = "R1";

  // reference model state
  bit         q[$];
  bit         mPrev = 0, mHoldFull = 0, mBusy = 0, mLine = 1, tickNow, base;
  logic [7:0] mHold = 8'h00, ch;
  int         mSyncIdx = 0;

  usart_tx u_usart_tx (
    .clk(clk), .rst(rst), .txClk(txClk), .ctsN(ctsN), .cmdTxEn(cmdTxEn),
    .cmdBreak(cmdBreak), .cfgSync(cfgSync), .cfgBaud(cfgBaud), .cfgLen(cfgLen),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd), .cfgStop(cfgStop),
    .cfgDualSync(cfgDualSync), .syncCharA(syncCharA), .syncCharB(syncCharB),
    .wrData(wrData), .dataIn(dataIn), .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  // transmit clock: period of four system clocks
  always @(negedge clk) begin
    divCnt = divCnt + 1;
    if (divCnt == 2) begin
      txClk = ~txClk;
      divCnt = 0;
    end
  end

  function automatic void pushBits(bit v, int n);
    for (int k = 0; k < n; k++) q.push_back(v);
  endfunction

  // Expected tick-by-tick line levels for one character (R4, R5, R6, R10).
  function automatic void buildFrame(logic [7:0] c);
    int  f, len, halves;
    bit  p;
    f   = cfgSync ? 1 : (cfgBaud == 2'b00 ? 1 : (cfgBaud == 2'b01 ? 16 : 64));
    len = 5 + int'(cfgLen);
    p   = cfgParOdd;
    for (int i = 0; i < len; i++) p = p ^ c[i];
    if (!cfgSync) pushBits(1'b0, f);
    for (int i = 0; i < len; i++) pushBits(c[i], f);
    if (cfgParEn) pushBits(p, f);
    if (!cfgSync) begin
      halves = (cfgStop == 2'b00) ? 2 : (cfgStop == 2'b01 ? 3 : 4);
      pushBits(1'b1, (halves * f + 1) / 2);
    end
  endfunction

  always @(posedge clk) begin
    tickNow = mPrev && !txClk;
    mPrev   = txClk;
    if (rst) begin
      q.delete();
      mHoldFull = 0; mBusy = 0; mLine = 1; mSyncIdx = 0;
    end else begin
      if (tickNow) begin
        if (!cmdTxEn) begin
          q.delete();
          mBusy = 0; mSyncIdx = 0; base = 1;
        end else begin
          if (q.size() == 0) begin
            if (!ctsN && mHoldFull) begin
              buildFrame(mHold);
              mHoldFull = 0; mBusy = 1; mSyncIdx = 0;
            end else if (!ctsN && cfgSync) begin
              ch = (cfgDualSync && mSyncIdx == 1) ? syncCharB : syncCharA;
              buildFrame(ch);
              mBusy = 0;
              mSyncIdx = cfgDualSync ? 1 - mSyncIdx : 0;
            end else begin
              mBusy = 0; mSyncIdx = 0;
            end
          end
          base = (q.size() > 0) ? q.pop_front() : 1'b1;
        end
        mLine = cmdBreak ? 1'b0 : base;
      end
      if (wrData) begin
        mHold = dataIn;
        mHoldFull = 1;
      end
    end
  end

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      checks = checks + 3;
      if (txd !== mLine) begin
        errors++;
        $display("FAIL %s txd actual %b expected %b at cycle %0d", curReq, txd, mLine, cyc);
      end
      if (txRdy !== !mHoldFull) begin
        errors++;
        $display("FAIL R8 txRdy actual %b expected %b at cycle %0d", txRdy, !mHoldFull, cyc);
      end
      if (txEmpty !== (!mHoldFull && !mBusy)) begin
        errors++;
        $display("FAIL R9/R11 txEmpty actual %b expected %b at cycle %0d",
                 txEmpty, (!mHoldFull && !mBusy), cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeChar(logic [7:0] d);
    while (mHoldFull) @(posedge clk);
    #1;
    wrData = 1'b1; dataIn = d;
    @(posedge clk); #1;
    wrData = 1'b0;
    @(negedge clk);
    chk("R8", "txRdy after write", txRdy, 1'b0);
    #1;
  endtask

  task automatic waitDone();
    int guard = 0;
    @(posedge clk);
    while ((mHoldFull || mBusy || q.size() != 0) && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    clocks(12);
  endtask

  initial begin
    clocks(6);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "txd after reset", txd, 1'b1);
    chk("R1", "txRdy after reset", txRdy, 1'b1);
    chk("R1", "txEmpty after reset", txEmpty, 1'b1);
    clocks(1);

    // R4, R7: x1 timing, 8 bits, no parity, double buffered
    curReq = "R4/R7";
    cmdTxEn = 1'b1;
    writeChar(8'hA5);
    writeChar(8'h3C);
    @(negedge clk);
    chk("R9", "txEmpty while sending", txEmpty, 1'b0);
    waitDone();

    // R5: x16, 7 bits, even parity, two stop bits
    curReq = "R5";
    cfgBaud = 2'b01; cfgLen = 2'b10; cfgParEn = 1'b1; cfgStop = 2'b10;
    writeChar(8'h55);
    writeChar(8'h7F);
    waitDone();

    // R6: one and a half stop bits at x16 and at x1, odd parity
    curReq = "R6";
    cfgLen = 2'b00; cfgParOdd = 1'b1; cfgStop = 2'b01;
    writeChar(8'h13);
    waitDone();
    cfgBaud = 2'b00;
    writeChar(8'h0F);
    writeChar(8'hF0);
    waitDone();

    // R5: x64 with 8 bits and odd parity
    curReq = "R5";
    cfgBaud = 2'b10; cfgLen = 2'b11; cfgStop = 2'b00;
    writeChar(8'h81);
    waitDone();

    // R3: clear-to-send holds the character back, later rise does not stop it
    curReq = "R3";
    cfgBaud = 2'b01;
    ctsN = 1'b1;
    writeChar(8'h66);
    clocks(40);
    @(negedge clk);
    chk("R3", "txd held at mark", txd, 1'b1);
    chk("R3", "txEmpty while held", txEmpty, 1'b0);
    #1;
    ctsN = 1'b0;
    clocks(30);
    ctsN = 1'b1;
    waitDone();
    ctsN = 1'b0;

    // R2: disabling mid-character drops it and keeps the held one
    curReq = "R2";
    writeChar(8'hC3);
    writeChar(8'h3C);
    clocks(20);
    cmdTxEn = 1'b0;
    clocks(20);
    @(negedge clk);
    chk("R2", "txd when disabled", txd, 1'b1);
    chk("R2", "held character kept", txEmpty, 1'b0);
    #1;
    cmdTxEn = 1'b1;
    waitDone();

    // R12: break during a character
    curReq = "R12";
    writeChar(8'hFF);
    clocks(30);
    cmdBreak = 1'b1;
    clocks(30);
    @(negedge clk);
    chk("R12", "txd during break", txd, 1'b0);
    #1;
    cmdBreak = 1'b0;
    waitDone();

    // R10, R11: synchronous mode with fill
    cmdTxEn = 1'b0;
    clocks(20);
    curReq = "R10/R11";
    cfgSync = 1'b1; cfgLen = 2'b11; cfgParEn = 1'b0; cfgDualSync = 1'b0;
    cmdTxEn = 1'b1;
    clocks(50);
    @(negedge clk);
    chk("R11", "txEmpty during fill", txEmpty, 1'b1);
    #1;
    writeChar(8'hC5);
    writeChar(8'h5A);
    clocks(150);
    cfgDualSync = 1'b1; cfgParEn = 1'b1;
    clocks(200);
    writeChar(8'h99);
    clocks(150);
    @(negedge clk);
    chk("R11", "txEmpty back in fill", txEmpty, 1'b1);
    #1;
    cmdTxEn = 1'b0;
    clocks(20);
    @(negedge clk);
    chk("R2", "txd after sync disable", txd, 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule